// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Detection

This block turns an asynchronous serial line into parallel characters for an 8-bit host bus. The line is sampled on a data-clock strobe (`samp_tick`, one cycle wide, one per external data clock edge). The strobe can be used directly, or divided by 16 or 64 with the start bit centred by a counter. Once a low level on the idle line has been confirmed as a start bit, the receiver shifts in 7 or 8 data bits, least significant first. It then checks an optional even or odd parity bit and one stop bit. The finished character is handed to a holding register, together with its parity and framing flags.

The holding register decouples the host from the line. The host sees a receive-full flag and reads the character with a one-cycle read strobe. If a second character completes before the first is read, that is an overrun. A carrier-detect input (active low) holds the receiver idle while the carrier is absent, and latches a carrier-lost flag. An interrupt request combines receive-full, overrun and carrier loss under an enable input. Framing, word length, parity and divide ratio come from static configuration inputs.

Top module: `serial_rx_adapter`

## Requirements
- R1: A synchronous active-high `rst` clears rx_full, err_overrun, err_parity, err_frame and carrier_lost, and returns the receiver to idle.
- R2: With cfg_div=1 (÷16) or cfg_div=2/3 (÷64), a low line seen on a tick is rechecked N/2 ticks later (N=16 or 64). Each following bit is then sampled every N ticks, least significant data bit first.
- R3: With cfg_div=0 (÷1), the tick that sees the line low takes the start bit, and every following tick samples exactly one bit.
- R4: In the ÷16 and ÷64 modes, a start bit that is high again at its mid-bit check is dropped: no character is produced and the receiver waits for the next low level.
- R5: With cfg_par_en=1, one parity bit follows the data. With cfg_par_odd=0 the data bits plus parity must hold an even number of ones; with cfg_par_odd=1, an odd number. A mismatch sets err_parity for that character. With cfg_par_en=0, err_parity is 0.
- R6: A low line at the stop-bit sample sets err_frame for that character.
- R7: cfg_wlen8=1 selects 8 data bits and cfg_wlen8=0 selects 7, with rx_data[7] reading 0. A completed character appears on rx_data with its own err_parity and err_frame, and sets rx_full.
- R8: A character that completes while rx_full is set and no read is made in that cycle is lost. err_overrun is set, and rx_data, err_parity and err_frame keep the unread character.
- R9: A one-cycle rd_strobe clears rx_full and err_overrun. When rd_strobe falls in the same cycle that a new character is delivered, the new character is loaded, rx_full stays set and err_overrun stays clear.
- R10: While dcd_n is high, no reception runs and any frame in progress is abandoned. carrier_lost is set while dcd_n is high, and it is cleared by rd_strobe once dcd_n is low.
- R11: irq is high exactly when cfg_irq_en is high and at least one of rx_full, err_overrun or carrier_lost is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| samp_tick | input | 1 | One-cycle strobe per data clock edge |
| rxd | input | 1 | Serial line, idle high |
| dcd_n | input | 1 | Carrier detect, low when carrier present |
| cfg_div | input | 2 | 0: ÷1, 1: ÷16, 2/3: ÷64 |
| cfg_wlen8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Host read of the holding register |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Holding register contains an unread character |
| err_parity | output | 1 | Parity error of held character |
| err_frame | output | 1 | Framing error of held character |
| err_overrun | output | 1 | A character was lost while full |
| carrier_lost | output | 1 | Carrier absence latched |
| irq | output | 1 | Interrupt request |

## Verification
The host read and the delivery of a new character into the holding register can land in the same clock cycle. This is the point where the overrun decision could go wrong. The bench first fills the holding register. It then sends a second frame and pulses rd_strobe on the exact cycle after the stop-bit tick, when the completed character is handed over. It expects rx_full still set, err_overrun clear and rx_data equal to the second character. A separate sequence sends two frames without a read, and expects the overrun flag with the first character kept.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        DIV_BY1  = 2'd0,
        DIV_BY16 = 2'd1,
        DIV_BY64 = 2'd2,
        DIV_RSVD = 2'd3
    } div_sel_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    // Number of ticks per bit for a divide selection
    function automatic int unsigned ticks_per_bit(input logic [1:0] sel,
                                                  input int unsigned fast,
                                                  input int unsigned slow);
        case (div_sel_e'(sel))
            DIV_BY1:  return 1;
            DIV_BY16: return fast;
            default:  return slow;
        endcase
    endfunction

endpackage

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_tick,
    input  logic       rxd,
    input  logic       dcd_n,
    input  logic [1:0] cfg_div,
    input  logic       cfg_wlen8,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       done,
    output rx_char_t   char_out
);
    localparam int CNT_W = $clog2(SLOW_DIV);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [3:0]        bitn;
    logic [CHAR_W-1:0] shreg;
    logic              par_acc;
    logic              perr_r;

    logic [CNT_W:0]    period;
    logic [CNT_W:0]    period_m1;
    logic [CNT_W:0]    half_m1;
    logic [3:0]        last_bit;
    logic              at_sample;
    logic              at_half;

    always_comb begin
        period    = (CNT_W+1)'(ticks_per_bit(cfg_div, FAST_DIV, SLOW_DIV));
        period_m1 = period - 1'b1;
        half_m1   = (period >> 1) - 1'b1;
        last_bit  = cfg_wlen8 ? 4'd7 : 4'd6;
        at_sample = (cnt == period_m1[CNT_W-1:0]);
        at_half   = (cnt == half_m1[CNT_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || dcd_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            perr_r   <= 1'b0;
            done     <= 1'b0;
            char_out <= '0;
        end else begin
            done <= 1'b0;
            if (samp_tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd) begin
                            cnt     <= '0;
                            bitn    <= '0;
                            shreg   <= '0;
                            par_acc <= 1'b0;
                            perr_r  <= 1'b0;
                            state   <= (period == 1) ? ST_DATA : ST_START;
                        end
                    end
                    ST_START: begin
                        if (at_half) begin
                            cnt   <= '0;
                            state <= rxd ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_sample) begin
                            cnt                <= '0;
                            shreg[bitn[2:0]]   <= rxd;
                            par_acc            <= par_acc ^ rxd;
                            bitn               <= bitn + 1'b1;
                            if (bitn == last_bit)
                                state <= cfg_par_en ? ST_PAR : ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_sample) begin
                            cnt    <= '0;
                            perr_r <= par_acc ^ rxd ^ cfg_par_odd;
                            state  <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_sample) begin
                            cnt           <= '0;
                            done          <= 1'b1;
                            char_out.data <= shreg;
                            char_out.perr <= perr_r & cfg_par_en;
                            char_out.ferr <= ~rxd;
                            state         <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> ({1'b0, cnt} < period)) else $error("count out of range"); // R2

    AST_CARRIER_IDLE: assert property (@(posedge clk) disable iff (rst)
        dcd_n |=> (state == ST_IDLE && !done)) else $error("busy without carrier"); // R10

    AST_SHORT_WORD: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg_wlen8 && $stable(cfg_wlen8)) |-> !char_out.data[7]) else $error("bit 7 in short word"); // R7

endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer
    import serial_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  rx_char_t char_in,
    input  logic     rd_strobe,
    output rx_char_t held,
    output logic     full,
    output logic     overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else if (load) begin
            if (!full || rd_strobe) begin
                held    <= char_in;
                full    <= 1'b1;
                overrun <= 1'b0;
            end else begin
                overrun <= 1'b1;
            end
        end else if (rd_strobe) begin
            full    <= 1'b0;
            overrun <= 1'b0;
        end
    end

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(full)) else $error("overrun without full"); // R8

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_strobe) |=> $stable(held)) else $error("unread char replaced"); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !load) |=> (!full && !overrun)) else $error("read did not clear"); // R9

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && load) |=> (full && !overrun)) else $error("read and load clash"); // R9

endmodule

// File: rtl/serial_rx_adapter.sv
module serial_rx_adapter
    import serial_rx_pkg::*;
#(
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_tick,
    input  logic              rxd,
    input  logic              dcd_n,
    input  logic [1:0]        cfg_div,
    input  logic              cfg_wlen8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_irq_en,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              carrier_lost
,
    output logic              irq
);
    logic     done;
    rx_char_t new_char;
    rx_char_t held;

    rx_frame_engine #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .samp_tick   (samp_tick),
        .rxd         (rxd),
        .dcd_n       (dcd_n),
        .cfg_div     (cfg_div),
        .cfg_wlen8   (cfg_wlen8),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .done        (done),
        .char_out    (new_char)
    );

    rx_hold_buffer u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (done),
        .char_in   (new_char),
        .rd_strobe (rd_strobe),
        .held      (held),
        .full      (rx_full),
        .overrun   (err_overrun)
    );

    always_ff @(posedge clk) begin
        if (rst)
            carrier_lost <= 1'b0;
        else if (dcd_n)
            carrier_lost <= 1'b1;
        else if (rd_strobe)
            carrier_lost <= 1'b0;
    end

    assign rx_data    = held.data;
    assign err_parity = held.perr;
    assign err_frame  = held.ferr;
    assign irq        = cfg_irq_en & (rx_full | err_overrun | carrier_lost);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!rx_full && !err_overrun && !carrier_lost)) else $error("reset left flags"); // R1

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg_irq_en |-> !irq) else $error("irq while disabled"); // R11

    AST_CARRIER_FLAG: assert property (@(posedge clk) disable iff (rst)
        dcd_n |=> carrier_lost) else $error("carrier loss not latched"); // R10

endmodule

// File: tb/serial_rx_adapter_test.sv
module serial_rx_adapter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       samp_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       dcd_n = 1'b0;
    logic [1:0] cfg_div = 2'd1;
    logic       cfg_wlen8 = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, err_parity, err_frame, err_overrun, carrier_lost, irq;

    int checks = 0;
    int failures = 0;
    bit auto_rd = 1'b0;
    bit done_run = 1'b0;
    int ratio = 16;
    int hf = 8;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    serial_rx_adapter uut (
        .clk (clk), .rst (rst), .samp_tick (samp_tick), .rxd (rxd), .dcd_n (dcd_n),
        .cfg_div (cfg_div), .cfg_wlen8 (cfg_wlen8), .cfg_par_en (cfg_par_en),
        .cfg_par_odd (cfg_par_odd), .cfg_irq_en (cfg_irq_en), .rd_strobe (rd_strobe),
        .rx_data (rx_data), .rx_full (rx_full), .err_parity (err_parity),
        .err_frame (err_frame), .err_overrun (err_overrun),
        .carrier_lost (carrier_lost), .irq (irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) samp_tick <= ~samp_tick;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic set_div(input logic [1:0] d);
        cfg_div = d;
        ratio = (d == 2'd0) ? 1 : (d == 2'd1) ? 16 : 64;
        hf = ratio / 2;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!samp_tick);
        end
    endtask

    task automatic send_bit(input logic v, input int n);
        @(negedge clk);
        rxd = v;
        wait_ticks(n);
    endtask

    task automatic expect_char(input logic [7:0] d, input logic pe, input logic fe, input string tag);
        exp_q.push_back({d, pe, fe});
        tag_q.push_back(tag);
    endtask

    // Sends one frame with the current configuration
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input bit rd_at_stop);
        logic [7:0] dm;
        logic       pbit;
        int         nb;
        nb = cfg_wlen8 ? 8 : 7;
        dm = cfg_wlen8 ? d : {1'b0, d[6:0]};
        pbit = cfg_par_odd ? ~^dm : ^dm;
        send_bit(1'b0, ratio);
        for (int i = 0; i < nb; i++) send_bit(dm[i], ratio);
        if (cfg_par_en) send_bit(pbit ^ bad_par, ratio);
        if (bad_stop) begin
            send_bit(1'b0, hf + 1);
            send_bit(1'b1, ratio);
        end else if (rd_at_stop) begin
            send_bit(1'b1, hf + 1);
            @(negedge clk) rd_strobe = 1'b1;
            @(negedge clk) rd_strobe = 1'b0;
            wait_ticks(ratio);
        end else begin
            send_bit(1'b1, ratio + 2);
        end
    endtask

    task automatic pulse_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops expected characters as the design delivers them
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd) begin
                if (rd_strobe) begin
                    rd_strobe = 1'b0;
                end else if (rx_full) begin
                    if (exp_q.size() == 0) begin
                        checks++;
                        failures++;
                        $display("FAIL R4/R10 unexpected char actual=%0h expected=none",
                                 {rx_data, err_parity, err_frame});
                    end else begin
                        logic [9:0] e;
                        string      t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(t, {22'd0, rx_data, err_parity, err_frame}, {22'd0, e});
                    end
                    rd_strobe = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset flags", {27'd0, rx_full, err_parity, err_frame, err_overrun, carrier_lost}, 32'd0);
        check("R1 reset irq", {31'd0, irq}, 32'd0);

        auto_rd = 1'b1;
        // R2: divide by 16, 8 bits, no parity
        set_div(2'd1);
        expect_char(8'hA5, 1'b0, 1'b0, "R2 div16 8-bit");
        send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
        // R7: 7-bit word, bit 7 reads 0
        cfg_wlen8 = 1'b0;
        expect_char(8'h43, 1'b0, 1'b0, "R7 7-bit word");
        send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
        cfg_wlen8 = 1'b1;
        drain();
        // R3: divide by 1
        set_div(2'd0);
        expect_char(8'h96, 1'b0, 1'b0, "R3 div1");
        send_frame(8'h96, 1'b0, 1'b0, 1'b0);
        expect_char(8'h01, 1'b0, 1'b0, "R3 div1 back-to-back");
        send_frame(8'h01, 1'b0, 1'b0, 1'b0);
        drain();
        // R5: divide by 64, even parity correct
        set_div(2'd2);
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        expect_char(8'h71, 1'b0, 1'b0, "R5 even parity good (div64 R2)");
        send_frame(8'h71, 1'b0, 1'b0, 1'b0);
        drain();
        set_div(2'd1);
        expect_char(8'h6E, 1'b1, 1'b0, "R5 even parity bad");
        send_frame(8'h6E, 1'b1, 1'b0, 1'b0);
        cfg_par_odd = 1'b1;
        expect_char(8'h3B, 1'b0, 1'b0, "R5 odd parity good");
        send_frame(8'h3B, 1'b0, 1'b0, 1'b0);
        expect_char(8'hF0, 1'b1, 1'b0, "R5 odd parity bad");
        send_frame(8'hF0, 1'b1, 1'b0, 1'b0);
        cfg_par_en = 1'b0;
        drain();
        // R4: false start, then one valid frame only
        send_bit(1'b0, 4);
        send_bit(1'b1, 2 * ratio);
        expect_char(8'h0F, 1'b0, 1'b0, "R4 after false start");
        send_frame(8'h0F, 1'b0, 1'b0, 1'b0);
        // R6: framing error
        expect_char(8'h55, 1'b0, 1'b1, "R6 framing error");
        send_frame(8'h55, 1'b0, 1'b1, 1'b0);
        drain();
        check("R4 queue empty", exp_q.size(), 32'd0);
        auto_rd = 1'b0;
        repeat (3) @(negedge clk);

        // R8/R11: overrun keeps the first character
        send_frame(8'h11, 1'b0, 1'b0, 1'b0);
        check("R7 full after frame", {31'd0, rx_full}, 32'd1);
        check("R11 irq gated off", {31'd0, irq}, 32'd0);
        @(negedge clk) cfg_irq_en = 1'b1;
        @(negedge clk);
        check("R11 irq on full", {31'd0, irq}, 32'd1);
        send_frame(8'h22, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R8 overrun set", {31'd0, err_overrun}, 32'd1);
        check("R8 data kept", {22'd0, rx_data, err_parity, err_frame}, {22'd0, 8'h11, 2'b00});
        pulse_read();
        @(negedge clk);
        check("R9 read clears", {30'd0, rx_full, err_overrun}, 32'd0);
        check("R11 irq cleared", {31'd0, irq}, 32'd0);

        // R9: read in the same cycle as delivery
        send_frame(8'h33, 1'b0, 1'b0, 1'b0);
        send_frame(8'h44, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 same-cycle full/ovr", {30'd0, rx_full, err_overrun}, 32'd2);
        check("R9 same-cycle data", {24'd0, rx_data}, 32'h44);
        pulse_read();

        // R10: carrier loss
        @(negedge clk) dcd_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 carrier lost", {31'd0, carrier_lost}, 32'd1);
        check("R11 irq on carrier", {31'd0, irq}, 32'd1);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
        check("R10 no reception", {31'd0, rx_full}, 32'd0);
        pulse_read();
        check("R10 held while absent", {31'd0, carrier_lost}, 32'd1);
        @(negedge clk) dcd_n = 1'b0;
        pulse_read();
        @(negedge clk);
        check("R10 cleared by read", {30'd0, carrier_lost, irq}, 32'd0);

        // R1: reset mid-state
        send_frame(8'h77, 1'b0, 1'b0, 1'b0);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1 reset clears full", {31'd0, rx_full}, 32'd0);

        finish_run();
    end

endmodule